// File: doc/BRIEF.md
# Configuration Register Write Decoder with Sticky Request Flag

This block sits on a simple synchronous register bus and turns write strobes into updates of a small configuration bank. Each write carries an address. Its upper bits must equal a base address fixed at build time, and its lower bits pick one of eight register slots. Two slots are populated: a DMA read start address and a DMA read length. Each one captures a slice of the write data taken from the most significant end of the bus.

Writing the length slot has a side effect. It raises a sticky read-request flag, which tells a downstream engine that a transfer has been programmed. The engine lowers the flag through a dedicated clear input. The clear has priority, so a clear that lands in the same cycle as a length write still leaves the flag low. The length value from that write is still stored.

Top module: `cfg_wr_bank`

## Requirements
- R1: A write takes effect only when `wr_stb` is 1 and `addr[9:3]` equals the base address (default 7'h2A). Any other write leaves both registers and the flag unchanged.
- R2: `addr[2:0]` selects the slot: 0 is the read address and 1 is the read length. A write to any of the offsets 2 to 7 changes no output.
- R3: A write to slot 0 loads `rd_addr_q` with `wdata[31:8]`, the top 24 bits, on the next clock edge.
- R4: A write to slot 1 loads `rd_len_q` with `wdata[31:16]`, the top 16 bits, on the next clock edge.
- R5: A write to slot 1 sets `rd_req` to 1 on the next edge when `rd_req_clr` is 0.
- R6: When `rd_req_clr` is 1, `rd_req` is 0 after the edge, even if a slot 1 write occurs in the same cycle. That write still updates `rd_len_q`.
- R7: `rd_req` keeps its value in any cycle without a slot 1 write and without a clear, including cycles that write slot 0.
- R8: A synchronous reset (`rst` = 1) drives `rd_addr_q`, `rd_len_q` and `rd_req` to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | Write strobe |
| addr | input | 10 | Base bits [9:3], slot offset [2:0] |
| wdata | input | 32 | Write data |
| rd_req_clr | input | 1 | Clears the read request flag; has priority over a set |
| rd_addr_q | output | 24 | DMA read start address register |
| rd_len_q | output | 16 | DMA read length register |
| rd_req | output | 1 | Sticky read request flag |

## Verification
Directed writes to each populated slot check which register is loaded and whether the flag moves. Writes with the strobe low, with a wrong base, and to empty offsets show that a write reaches nothing outside its own slot. A length write paired with a clear separates clear-over-set priority from set-over-clear. A slot 0 write made while the flag is high shows that only the length slot touches the flag. A long random stream then mixes hits, near-miss bases, all eight offsets and random clears against a behavioural model.

// File: rtl/cfg_wr_bank_pkg.sv
package cfg_wr_bank_pkg;
   // Slot select field width: fixed by the bus address split.
   localparam int SLOT_W = 3;
   localparam int NSLOT  = 1 << SLOT_W;
   // Slot offsets decoded by software drivers; kept stable.
   localparam logic [SLOT_W-1:0] SLOT_RD_ADDR = 3'd0;
   localparam logic [SLOT_W-1:0] SLOT_RD_LEN  = 3'd1;
endpackage

// File: rtl/cfg_wr_decode.sv
module cfg_wr_decode
   import cfg_wr_bank_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter logic [ADDR_W-SLOT_W-1:0] BASE = '0
) (
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] addr,
   output logic [NSLOT-1:0]  slot_we
);
   localparam int BASE_W = ADDR_W - SLOT_W;

   logic hit;
   assign hit = wr_stb && (addr[ADDR_W-1 -: BASE_W] == BASE);

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign slot_we[s] = hit && (addr[SLOT_W-1:0] == SLOT_W'(s));
   end

   always_comb begin
      a_r2_onehot_select : assert ($onehot0(slot_we));
   end
endmodule

// File: rtl/cfg_wr_field.sv
module cfg_wr_field #(
   parameter int DATA_W = 32,
   parameter int W      = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [W-1:0]      q
);
   if (W < 1 || W > DATA_W) begin : g_bad_w
      $error("cfg_wr_field: W must lie in 1..DATA_W");
   end

   always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (we) q <= wdata[DATA_W-1 -: W];
   end

   a_r3_r4_capture_msb : assert property (@(posedge clk) disable iff (rst)
      we |=> (q == $past(wdata[DATA_W-1 -: W])));
   a_r1_hold_unwritten : assert property (@(posedge clk) disable iff (rst)
      !we |=> $stable(q));
endmodule

// File: rtl/cfg_wr_reqflag.sv
module cfg_wr_reqflag (
   input  logic clk,
   input  logic rst,
   input  logic set,
   input  logic clr,
   output logic req
);
   always_ff @(posedge clk) begin
      if (rst || clr) req <= 1'b0;
      else if (set)   req <= 1'b1;
   end

   a_r6_clear_wins : assert property (@(posedge clk) disable iff (rst)
      clr |=> !req);
   a_r5_set_raises : assert property (@(posedge clk) disable iff (rst)
      (set && !clr) |=> req);
   a_r7_holds : assert property (@(posedge clk) disable iff (rst)
      (!set && !clr) |=> $stable(req));
endmodule

// File: rtl/cfg_wr_bank.sv
module cfg_wr_bank
   import cfg_wr_bank_pkg::*;
#(
   parameter int ADDR_W  = 10,
   parameter int DATA_W  = 32,
   parameter int RADDR_W = 24,
   parameter int RLEN_W  = 16,
   parameter logic [ADDR_W-SLOT_W-1:0] BASE = 7'h2A
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_stb,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic               rd_req_clr,
   output logic [RADDR_W-1:0] rd_addr_q,
   output logic [RLEN_W-1:0]  rd_len_q,
   output logic               rd_req
);
   if (ADDR_W <= SLOT_W) begin : g_bad_addr
      $error("cfg_wr_bank: ADDR_W must exceed the slot field width");
   end
   if (SLOT_RD_ADDR == SLOT_RD_LEN) begin : g_bad_slots
      $error("cfg_wr_bank: slot offsets must differ");
   end

   logic [NSLOT-1:0] slot_we;

   cfg_wr_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
      .wr_stb (wr_stb),
      .addr   (addr),
      .slot_we(slot_we)
   );

   cfg_wr_field #(.DATA_W(DATA_W), .W(RADDR_W)) u_rd_addr (
      .clk  (clk),
      .rst  (rst),
      .we   (slot_we[SLOT_RD_ADDR]),
      .wdata(wdata),
      .q    (rd_addr_q)
   );

   cfg_wr_field #(.DATA_W(DATA_W), .W(RLEN_W)) u_rd_len (
      .clk  (clk),
      .rst  (rst),
      .we   (slot_we[SLOT_RD_LEN]),
      .wdata(wdata),
      .q    (rd_len_q)
   );

   cfg_wr_reqflag u_rd_req (
      .clk(clk),
      .rst(rst),
      .set(slot_we[SLOT_RD_LEN]),
      .clr(rd_req_clr),
      .req(rd_req)
   );

   a_r8_reset_clears : assert property (@(posedge clk)
      rst |=> (rd_addr_q == '0 && rd_len_q == '0 && !rd_req));
   a_r1_miss_no_change : assert property (@(posedge clk) disable iff (rst)
      (!wr_stb || addr[ADDR_W-1 -: ADDR_W-SLOT_W] != BASE)
      |=> ($stable(rd_addr_q) && $stable(rd_len_q)));
   a_r1_miss_no_set : assert property (@(posedge clk) disable iff (rst)
      (!wr_stb || addr[ADDR_W-1 -: ADDR_W-SLOT_W] != BASE) |=> !$rose(rd_req));
endmodule

// File: tb/tb_cfg_wr_bank.sv
module tb_cfg_wr_bank;
   localparam logic [6:0] BASE = 7'h2A;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_stb = 1'b0;
   logic [9:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        rd_req_clr = 1'b0;
   logic [23:0] rd_addr_q;
   logic [15:0] rd_len_q;
   logic        rd_req;

   int n_run = 0;
   int n_fail = 0;

   logic [23:0] m_addr = '0;
   logic [15:0] m_len = '0;
   logic        m_req = 1'b0;

   always #5 clk = ~clk;

   cfg_wr_bank dut (
      .clk(clk), .rst(rst), .wr_stb(wr_stb), .addr(addr), .wdata(wdata),
      .rd_req_clr(rd_req_clr), .rd_addr_q(rd_addr_q), .rd_len_q(rd_len_q),
      .rd_req(rd_req)
   );

   task automatic compare(input string tag);
      n_run++;
      if (rd_addr_q !== m_addr || rd_len_q !== m_len || rd_req !== m_req) begin
         n_fail++;
         $display("FAIL %s: addr=%h len=%h req=%b expected addr=%h len=%h req=%b",
                  tag, rd_addr_q, rd_len_q, rd_req, m_addr, m_len, m_req);
      end
   endtask

   task automatic cyc(input logic r, input logic w, input logic [9:0] a,
                      input logic [31:0] d, input logic c, input string tag);
      bit hit;
      @(negedge clk);
      rst = r; wr_stb = w; addr = a; wdata = d; rd_req_clr = c;
      @(posedge clk);
      hit = w && (a[9:3] == BASE);
      if (r) begin
         m_addr = '0; m_len = '0; m_req = 1'b0;
      end else begin
         if (hit && a[2:0] == 3'd0) m_addr = d[31:8];
         if (hit && a[2:0] == 3'd1) m_len = d[31:16];
         if (c) m_req = 1'b0;
         else if (hit && a[2:0] == 3'd1) m_req = 1'b1;
      end
      #1 compare(tag);
   endtask

   function automatic logic [9:0] ad(input logic [6:0] b, input logic [2:0] s);
      return {b, s};
   endfunction

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) cyc(1, 0, '0, '0, 0, "R8 reset");
      cyc(0, 1, ad(BASE, 0), 32'hDEADBEEF, 0, "R3 addr write");
      cyc(0, 1, ad(BASE, 1), 32'h1234ABCD, 0, "R4/R5 len write");
      cyc(0, 0, ad(BASE, 1), 32'h0, 0, "R7 idle hold");
      cyc(0, 1, ad(BASE, 0), 32'hCAFEF00D, 0, "R7 addr write keeps req");
      cyc(0, 0, '0, '0, 1, "R6 clear alone");
      cyc(0, 1, ad(BASE, 1), 32'h55AA0000, 0, "R5 set again");
      cyc(0, 1, ad(BASE, 1), 32'h77660000, 1, "R6 clear beats write");
      cyc(0, 1, ad(7'h2B, 1), 32'hFFFFFFFF, 0, "R1 wrong base");
      cyc(0, 0, ad(BASE, 1), 32'hFFFFFFFF, 0, "R1 strobe low");
      cyc(0, 1, ad(BASE, 5), 32'hFFFFFFFF, 0, "R2 empty offset 5");
      cyc(0, 1, ad(BASE, 2), 32'h0BADF00D, 0, "R2 empty offset 2");
      cyc(0, 1, ad(BASE, 7), 32'h0BADF00D, 0, "R2 empty offset 7");
      cyc(0, 1, ad(BASE, 1), 32'h00010000, 0, "R5 set before reset");
      cyc(1, 1, ad(BASE, 0), 32'hFFFFFFFF, 0, "R8 reset over write");
      for (int i = 0; i < 4000; i++) begin
         logic [6:0] b;
         b = ($urandom % 4 == 0) ? 7'($urandom) : BASE;
         cyc(($urandom % 500) == 0, ($urandom % 3) != 0, ad(b, 3'($urandom)),
             $urandom, ($urandom % 6) == 0, "R2 random mix");
      end
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule